// File: doc/BRIEF.md
# Configurable Multiple-Input Signature Register

This block is an n-stage shift register with linear feedback. Software or test control picks its feedback polynomial at run time, and every stage also takes in one bit of an external parallel word on each enabled clock. The stages shift from the most significant end toward the least significant end. The most significant stage receives the modulo-2 sum of the tapped stages, and that sum is further combined with its own input bit.

The block serves two purposes. As a test-pair source, it is reseeded and run with a constant nonzero input word, and each input word yields its own sequence of consecutive state pairs. As a response compactor, a circuit's outputs are driven into the input word and the final state is read as a signature. When the input word is held at zero, the block is a plain configurable linear-feedback shift register.

The seed and the tap mask are captured together on a load cycle. The tap mask takes effect from the next cycle onward.

Top module: `cfg_misr`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes `RESET_SEED` (default 8'h01) and the active tap mask becomes `DEFAULT_TAPS` (default 8'h03). Both take effect after that edge.
- R2: When `load` is high at a clock edge, `state` becomes `seed_in` and the active tap mask becomes `taps_in`. This happens whatever the value of `step_en`.
- R3: When both `load` and `step_en` are low, `state` keeps its value.
- R4: On a step (`step_en` high, `load` low), for every bit j below WIDTH-1, the next `state[j]` equals the current `state[j+1]` XOR `din[j]`.
- R5: On a step, the next `state[WIDTH-1]` equals the XOR of all current state bits whose tap-mask bit is 1, XORed with `din[WIDTH-1]`. Tap bit j selects `state[j]`.
- R6: After a seed load and a known stream of input words, the final state equals the signature that a bit-level model computes. This holds for at least two different tap masks.
- R7: A change on `taps_in` or `seed_in` while `load` is low has no effect on the sequence of states.
- R8: With `din` held at zero, the sequence of states equals that of a plain feedback shift register with the same tap mask.
- R9: With `din` at zero, an all-zero state stays all-zero on every step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures seed and tap mask; has priority over step_en |
| seed_in | input | WIDTH | Seed value to load into the state |
| taps_in | input | WIDTH | Polynomial coefficients; bit j taps state[j] |
| din | input | WIDTH | Parallel input word, one bit per stage |
| step_en | input | 1 | Advance the register by one step |
| state | output | WIDTH | Registered register contents |

## Verification
The bench targets the priority between load and step. A design that let `step_en` win would shift the value it had just loaded, or would skip the load. It also changes `taps_in` and `seed_in` between loads: a design that used the live coefficient inputs would drift off the model at once. Signatures are compared for two tap masks and for constant and varying input words. A wrong tap-to-bit mapping, or an input bit folded into the wrong stage, shows up as a bad most significant bit or a bad shifted bit. Runs with zero input and the all-zero lockup case show whether the input XOR disturbs plain shift-register behaviour.

// File: rtl/misr_pkg.sv
package misr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } misr_op_e;
endpackage

// File: rtl/misr_ctrl.sv
module misr_ctrl
  import misr_pkg::*;
(
  input  logic     load,
  input  logic     step_en,
  output misr_op_e op
);
  always_comb begin
    if (load)         op = OP_LOAD;
    else if (step_en) op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/misr_feedback.sv
module misr_feedback #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] taps,
  output logic             fb
);
  logic [WIDTH:0] acc;
  assign acc[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    assign acc[i+1] = acc[i] ^ (cur[i] & taps[i]);
  end
  assign fb = acc[WIDTH];
endmodule

// File: rtl/misr_stage_row.sv
module misr_stage_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  input  logic             fb,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;
  for (genvar j = 0; j < WIDTH; j++) begin : g_stage
    if (j == TOP) begin : g_head
      assign nxt[j] = fb ^ din[j];
    end else begin : g_body
      assign nxt[j] = cur[j+1] ^ din[j];
    end
  end
endmodule

// File: rtl/cfg_misr.sv
module cfg_misr
  import misr_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] RESET_SEED   = WIDTH'(1),
  parameter logic [WIDTH-1:0] DEFAULT_TAPS = WIDTH'(3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed_in,
  input  logic [WIDTH-1:0] taps_in,
  input  logic [WIDTH-1:0] din,
  input  logic             step_en,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] taps_q;
  logic [WIDTH-1:0] next_w;
  logic             fb_w;
  misr_op_e         op_w;

  misr_ctrl u_ctrl (
    .load    (load),
    .step_en (step_en),
    .op      (op_w)
  );

  misr_feedback #(.WIDTH(WIDTH)) u_fb (
    .cur  (state_q),
    .taps (taps_q),
    .fb   (fb_w)
  );

  misr_stage_row #(.WIDTH(WIDTH)) u_row (
    .cur (state_q),
    .din (din),
    .fb  (fb_w),
    .nxt (next_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_SEED;
      taps_q  <= DEFAULT_TAPS;
    end else begin
      case (op_w)
        OP_LOAD: begin
          state_q <= seed_in;
          taps_q  <= taps_in;
        end
        OP_STEP: state_q <= next_w;
        default: state_q <= state_q;
      endcase
    end
  end

  assign state = state_q;
endmodule

// File: rtl/cfg_misr_chk.sv
module cfg_misr_chk #(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] RESET_SEED = WIDTH'(1)
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             step_en,
  input logic [WIDTH-1:0] seed_in,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] state,
  input logic [WIDTH-1:0] taps
);
  // R1
  reset_seed_chk: assert property (@(posedge clk) rst |=> state == RESET_SEED);

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed_in));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> $stable(state));

  // R4
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1] ^ din[WIDTH-2:0]));

  // R5
  head_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load) |=> state[WIDTH-1] == ($past(^(state & taps)) ^ $past(din[WIDTH-1])));

  // R9
  lockup_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && state == '0 && din == '0) |=> state == '0);
endmodule

bind cfg_misr cfg_misr_chk #(.WIDTH(WIDTH), .RESET_SEED(RESET_SEED)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (load),
  .step_en (step_en),
  .seed_in (seed_in),
  .din     (din),
  .state   (state),
  .taps    (taps_q)
);

// File: tb/cfg_misr_test.sv
module cfg_misr_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic         step_en = 1'b0;
  logic [W-1:0] seed_in = '0;
  logic [W-1:0] taps_in = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] state;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] m_state;
  logic [W-1:0] m_taps;

  always #5 clk = ~clk;

  cfg_misr #(.WIDTH(W), .RESET_SEED(8'h01), .DEFAULT_TAPS(8'h03)) uut (
    .clk(clk), .rst(rst), .load(load), .seed_in(seed_in), .taps_in(taps_in),
    .din(din), .step_en(step_en), .state(state)
  );

  function automatic logic [W-1:0] misr_next(logic [W-1:0] q, logic [W-1:0] t, logic [W-1:0] d);
    logic fb = 1'b0;
    for (int i = 0; i < W; i++) if (t[i]) fb = fb ^ q[i];
    return {fb, q[W-1:1]} ^ d;
  endfunction

  function automatic logic [W-1:0] lfsr_next(logic [W-1:0] q, logic [W-1:0] t);
    logic fb = 1'b0;
    for (int i = 0; i < W; i++) if (t[i]) fb = fb ^ q[i];
    return {fb, q[W-1:1]};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(logic l, logic e, logic [W-1:0] s, logic [W-1:0] t, logic [W-1:0] d, bit chk);
    load = l; step_en = e; seed_in = s; taps_in = t; din = d;
    @(posedge clk);
    @(negedge clk);
    if (l) begin
      m_state = s; m_taps = t;
      if (chk) check("R2", state, m_state);
    end else if (e) begin
      m_state = misr_next(m_state, m_taps, d);
      if (chk) begin
        check("R4", {1'b0, state[W-2:0]}, {1'b0, m_state[W-2:0]});
        check("R5", {7'd0, state[W-1]}, {7'd0, m_state[W-1]});
      end
    end else if (chk) check("R3", state, m_state);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_state = 8'h01; m_taps = 8'h03;
    check("R1", state, 8'h01);
    // R1: default taps active after reset
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, 1'b1, '0, '0, '0, 1'b0);
      check("R1", state, m_state);
    end

    // R2: load beats step
    cyc(1'b1, 1'b1, 8'hA5, 8'hB8, 8'hFF, 1'b1);
    // R3: hold with noise on data and live config
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 8'h3C, 8'h55, 8'hC3, 1'b1);

    // R7: taps_in changes without load do nothing
    for (int k = 0; k < 12; k++) begin
      cyc(1'b0, 1'b1, 8'(k * 29), 8'(k * 71 + 1), 8'h00, 1'b0);
      check("R7", state, m_state);
    end

    // R8: zero input equals plain LFSR, two masks
    for (int p = 0; p < 2; p++) begin
      logic [W-1:0] ref_q;
      logic [W-1:0] tm;
      tm = (p == 0) ? 8'hB8 : 8'h8E;
      ref_q = 8'h5A;
      cyc(1'b1, 1'b0, 8'h5A, tm, '0, 1'b1);
      for (int k = 0; k < 40; k++) begin
        cyc(1'b0, 1'b1, '0, '0, '0, 1'b0);
        ref_q = lfsr_next(ref_q, tm);
        check("R8", state, ref_q);
      end
    end

    // R9: zero lockup
    cyc(1'b1, 1'b0, 8'h00, 8'hB8, '0, 1'b1);
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, '0, '0, '0, 1'b0);
    check("R9", state, 8'h00);

    // R6: signature after known stream, two masks, varying and constant input
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] tm;
      logic [W-1:0] sig;
      logic [W-1:0] dv;
      tm = (p % 2 == 0) ? 8'hB8 : 8'h1D;
      sig = 8'hFF;
      cyc(1'b1, 1'b0, 8'hFF, tm, '0, 1'b0);
      for (int k = 0; k < 64; k++) begin
        dv = (p < 2) ? 8'((k * 37) ^ (k >> 1)) : 8'h6B;
        sig = misr_next(sig, tm, dv);
        cyc(1'b0, 1'b1, '0, '0, dv, 1'b0);
      end
      check("R6", state, sig);
    end

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic l;
      logic e;
      logic [W-1:0] d;
      l = ($urandom % 16) == 0;
      e = ($urandom % 4) != 0;
      d = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      cyc(l, e, 8'($urandom), 8'($urandom), d, 1'b1);
    end

    // R1: reset mid-run
    rst = 1'b1; step_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", state, 8'h01);
    finish_run();
  end
endmodule